// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two access ports of a dual-port memory. It flags the cycles in which both ports are enabled on the same address. It does not contain the memory array. When the two ports collide, the port that settled on the address first keeps its access. The other port sees an active-low busy flag, and any write from that port is killed through a per-port write-kill output. Arbitration looks only at the enables and the addresses, never at read or write.

A mode input selects one of two roles.

- **Master:** the block computes busy itself and drives it out.
- **Slave:** the block drives its busy outputs high and ignores collisions. It takes a per-port busy level from outside and uses it only to kill writes.

This lets one master decide for a row of slaves that sit side by side to widen the data word.

Arrival order is judged once per clock cycle. A port is "settled" in a cycle if it was enabled on the same address in the previous cycle. A port that was not settled is "new". When both ports arrive in the same cycle, the left port wins. Once a winner is picked, it is held for as long as the collision lasts.

Top module: `dp_collision_arb`

## Requirements
- R1: In master mode, when the enables are not both high or the addresses differ, busy_l_n and busy_r_n are both 1.
- R2: The read/write inputs (l_wr, r_wr; 1 = write) never change which port wins or when busy is shown.
- R3: In master mode, if one port is settled and the other is new when they first collide, the new port's busy goes to 0 in that same cycle and the settled port's busy stays 1.
- R4: If both ports are new when they first collide, the left port wins and busy_r_n is 0.
- R5: busy_l_n and busy_r_n are never 0 in the same cycle.
- R6: While the collision lasts, the winner is held. This holds even if both addresses move together to another shared address, or if read/write changes.
- R7: Busy returns to 1 in the same cycle that the addresses stop matching or either enable drops.
- R8: In master mode, wr_kill_x is 1 exactly when port x is enabled, is writing, and its own busy output is 0. The busy_x_in inputs have no effect in this mode.
- R9: In slave mode (mode_slave = 1), both busy outputs are 1 and wr_kill_x equals x_en & x_wr & ~busy_x_in. A low busy input blocks only writes, and high inputs give normal operation.
- R10: While rst is 1 (synchronous, active high), both busy outputs are 1 and both write-kills are 0. Reset clears the stored winner and the arrival history, so a collision held across reset release counts as a same-cycle tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_slave | input | 1 | 1 = slave role, 0 = master role |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write (1) or read (0) |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write (1) or read (0) |
| busy_l_in | input | 1 | Left busy level from the master, active low (used in slave mode) |
| busy_r_in | input | 1 | Right busy level from the master, active low (used in slave mode) |
| busy_l_n | output | 1 | Left busy, active low |
| busy_r_n | output | 1 | Right busy, active low |
| wr_kill_l | output | 1 | Left write-kill, active high |
| wr_kill_r | output | 1 | Right write-kill, active high |

## Verification
The bench builds the block with ADDR_W = 4. With that width, the all-ones and all-zeros addresses and several near-miss pairs can be reached in a short vector table.

The vector sequence is ordered so that the arrival history sets up each case:
- settled against new, from both sides;
- a same-cycle tie;
- a held winner while both addresses move together;
- the slave role with each busy input level.

Directed tests then put a collision across a reset pulse and check the tie rule that follows the release.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_t;

  // Right wins only when it was settled and left was not; ties go left.
  function automatic win_t pick_winner(input logic l_settled, input logic r_settled);
    return (r_settled && !l_settled) ? WIN_RIGHT : WIN_LEFT;
  endfunction

  // Effective busy for one side: master uses arbitration, slave uses the pin.
  function automatic logic side_blocked(input logic slave, input logic lost, input logic pin_n);
    return slave ? !pin_n : lost;
  endfunction

endpackage

// File: rtl/dpa_port_hist.sv
module dpa_port_hist #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);

  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // Enabled on the same address in the previous cycle as well.
  assign settled = en && en_q && (addr == addr_q);

endmodule

// File: rtl/dpa_winner.sv
module dpa_winner
  import dpa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic l_settled,
  input  logic r_settled,
  output win_t win
);

  win_t win_q;
  win_t fresh;

  assign fresh = pick_winner(l_settled, r_settled);

  always_comb begin
    if (!hit)                 win = WIN_NONE;
    else if (win_q == WIN_NONE) win = fresh;
    else                      win = win_q;
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= WIN_NONE;
    else     win_q <= win;
  end

endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_slave,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              busy_l_in,
  input  logic              busy_r_in,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              wr_kill_l,
  output logic              wr_kill_r
);

  logic hit_w;
  logic l_settled_w, r_settled_w;
  win_t win_w;
  logic lost_l_w, lost_r_w;
  logic blk_l_w, blk_r_w;

  assign hit_w = l_en && r_en && (l_addr == r_addr);

  dpa_port_hist #(.ADDR_W(ADDR_W)) u_hist_l (
    .clk(clk), .rst(rst), .en(l_en), .addr(l_addr), .settled(l_settled_w)
  );

  dpa_port_hist #(.ADDR_W(ADDR_W)) u_hist_r (
    .clk(clk), .rst(rst), .en(r_en), .addr(r_addr), .settled(r_settled_w)
  );

  dpa_winner u_win (
    .clk(clk), .rst(rst), .hit(hit_w),
    .l_settled(l_settled_w), .r_settled(r_settled_w), .win(win_w)
  );

  assign lost_l_w = (win_w == WIN_RIGHT);
  assign lost_r_w = (win_w == WIN_LEFT);

  assign busy_l_n = !(!rst && !mode_slave && lost_l_w);
  assign busy_r_n = !(!rst && !mode_slave && lost_r_w);

  assign blk_l_w = side_blocked(mode_slave, lost_l_w, busy_l_in);
  assign blk_r_w = side_blocked(mode_slave, lost_r_w, busy_r_in);

  assign wr_kill_l = !rst && l_en && l_wr && blk_l_w;
  assign wr_kill_r = !rst && r_en && r_wr && blk_r_w;

endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_slave,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              busy_l_in,
  input logic              busy_r_in,
  input logic              busy_l_n,
  input logic              busy_r_n,
  input logic              wr_kill_l,
  input logic              wr_kill_r,
  input logic              hit_w
);

  // R5
  busy_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !(!busy_l_n && !busy_r_n));

  // R1
  no_hit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_en && r_en && (l_addr == r_addr)) |-> (busy_l_n && busy_r_n));

  // R6
  winner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hit_w && $past(hit_w) && !mode_slave && !$past(mode_slave))
      |-> ($stable(busy_l_n) && $stable(busy_r_n)));

  // R8
  master_kill_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_slave |-> ((wr_kill_l == (l_en && l_wr && !busy_l_n)) &&
                     (wr_kill_r == (r_en && r_wr && !busy_r_n))));

  // R9
  slave_role_chk: assert property (@(posedge clk) disable iff (rst)
    mode_slave |-> (busy_l_n && busy_r_n &&
                    (wr_kill_l == (l_en && l_wr && !busy_l_in)) &&
                    (wr_kill_r == (r_en && r_wr && !busy_r_in))));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (busy_l_n && busy_r_n && !wr_kill_l && !wr_kill_r));

endmodule

bind dp_collision_arb dpa_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mode_slave(mode_slave),
  .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
  .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
  .busy_l_in(busy_l_in), .busy_r_in(busy_r_in),
  .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
  .wr_kill_l(wr_kill_l), .wr_kill_r(wr_kill_r),
  .hit_w(hit_w)
);

// File: tb/sim_dp_collision_arb.sv
module sim_dp_collision_arb;

  localparam int CLK_T = 10;
  localparam int AW    = 4;

  typedef struct packed {
    logic [3:0]    req;
    logic          slv;
    logic          le;
    logic [AW-1:0] la;
    logic          lw;
    logic          re;
    logic [AW-1:0] ra;
    logic          rw;
    logic          bli;
    logic          bri;
    logic          ebl;
    logic          ebr;
    logic          ekl;
    logic          ekr;
  } vec_t;

  localparam int NV = 22;
  // req slv  le la lw  re ra rw  bli bri  ebl ebr ekl ekr
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 idle
    '{4'd1, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 one side
    '{4'd1, 1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 4'd5,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 mismatch
    '{4'd3, 1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 right late
    '{4'd8, 1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R8 kill right
    '{4'd2, 1'b0, 1'b1, 4'd3,  1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 rw swap
    '{4'd8, 1'b0, 1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R8 pins ignored
    '{4'd7, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0, 4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 enable drop
    '{4'd1, 1'b0, 1'b0, 4'd3,  1'b1, 1'b1, 4'd9,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1
    '{4'd3, 1'b0, 1'b1, 4'd9,  1'b1, 1'b1, 4'd9,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 left late
    '{4'd7, 1'b0, 1'b1, 4'd9,  1'b1, 1'b1, 4'd10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 address split
    '{4'd1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 4'd15, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1
    '{4'd3, 1'b0, 1'b1, 4'd15, 1'b1, 1'b1, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 all-ones
    '{4'd6, 1'b0, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 move together
    '{4'd6, 1'b0, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 rw change
    '{4'd1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 idle
    '{4'd4, 1'b0, 1'b1, 4'd15, 1'b0, 1'b1, 4'd15, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 tie
    '{4'd9, 1'b1, 1'b1, 4'd2,  1'b1, 1'b1, 4'd2,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 normal
    '{4'd9, 1'b1, 1'b1, 4'd2,  1'b1, 1'b1, 4'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 left pin low
    '{4'd9, 1'b1, 1'b1, 4'd2,  1'b0, 1'b1, 4'd2,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R9 read passes
    '{4'd9, 1'b1, 1'b1, 4'd2,  1'b1, 1'b0, 4'd2,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 disabled
    '{4'd3, 1'b0, 1'b1, 4'd2,  1'b1, 1'b1, 4'd2,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R3 after slave
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_slave = 1'b0;
  logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          busy_l_in = 1'b1, busy_r_in = 1'b1;
  logic          busy_l_n, busy_r_n, wr_kill_l, wr_kill_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  dp_collision_arb #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .mode_slave(mode_slave),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .busy_l_in(busy_l_in), .busy_r_in(busy_r_in),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .wr_kill_l(wr_kill_l), .wr_kill_r(wr_kill_r)
  );

  task automatic check4(input int req, input string what,
                        input logic ebl, input logic ebr, input logic ekl, input logic ekr);
    logic [3:0] act, exp;
    act = {busy_l_n, busy_r_n, wr_kill_l, wr_kill_r};
    exp = {ebl, ebr, ekl, ekr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: {busy_l,busy_r,kill_l,kill_r} actual %b expected %b", req, what, act, exp);
    end
    // R5 checked on every sample
    checks++;
    if (!busy_l_n && !busy_r_n) begin
      fails++;
      $display("FAIL R5 %s: both busy low actual %b%b expected not 00", what, busy_l_n, busy_r_n);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_slave = v.slv;
    l_en = v.le; l_addr = v.la; l_wr = v.lw;
    r_en = v.re; r_addr = v.ra; r_wr = v.rw;
    busy_l_in = v.bli; busy_r_in = v.bri;
  endtask

  initial begin
    #(CLK_T * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state with idle inputs
    repeat (2) @(negedge clk);
    #(CLK_T/2 - 1);
    check4(10, "reset idle", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #(CLK_T/2 - 1);
      check4(int'(VEC[i].req), $sformatf("vector %0d", i),
             VEC[i].ebl, VEC[i].ebr, VEC[i].ekl, VEC[i].ekr);
    end

    // R10: collision with right losing, then reset pulse over it
    @(negedge clk);
    mode_slave = 1'b0; busy_l_in = 1'b1; busy_r_in = 1'b1;
    l_en = 1'b1; l_addr = 4'd7; l_wr = 1'b1;
    r_en = 1'b0; r_addr = 4'd7; r_wr = 1'b1;
    @(negedge clk);
    r_en = 1'b1;
    #(CLK_T/2 - 1);
    check4(3, "pre-reset collision", 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    #(CLK_T/2 - 1);
    check4(10, "reset over collision", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    #(CLK_T/2 - 1);
    check4(10, "reset held", 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #(CLK_T/2 - 1);
    // R10 / R4: history cleared, so release is a tie and left wins
    check4(10, "post-reset tie", 1'b1, 1'b0, 1'b0, 1'b1);
    // R6: swap read/write, winner stays left
    @(negedge clk);
    l_wr = 1'b0; r_wr = 1'b0;
    #(CLK_T/2 - 1);
    check4(6, "post-reset hold", 1'b1, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule